// File: doc/BRIEF.md
# Multi-Mode External Request Detector

This block watches a bank of asynchronous external request lines. Each line has its own detection condition: a rising edge, a falling edge, a high level or a low level. When a line's condition is met, its flag is set. The flag is then routed to one of two destinations, chosen per channel: a CPU interrupt request, or a start request for a hardware data-transfer engine. The transfer engine and interrupt priority arbitration sit outside this block.

A separate wake-up output is raised whenever any input that is enabled for wake-up sits at a low level. This path does not depend on the per-channel request enables. The configuration registers live in the surrounding register file and reach the block as plain vectors. Flag clearing arrives as write-one pulses, and the transfer engine returns a per-channel acknowledge.

Top module: `xreq_detect`

## Requirements
- R1: After reset, every flag, every interrupt request, every transfer request and the wake-up output are 0.
- R2: In mode 00 (rising edge), a low-to-high input change sets the channel flag on the third clock edge after the change, and not before. The flag stays set after the input returns low.
- R3: In mode 01 (falling edge), a high-to-low input change sets the flag with the same three-edge latency and stays set.
- R4: In mode 10 (high level), the flag follows the input. It rises three edges after the input goes high and falls three edges after the input goes low.
- R5: In mode 11 (low level), the flag is 1 while the synchronized input is low and 0 while it is high, with the same latency.
- R6: A one-cycle pulse on a channel's clear bit clears an edge-mode flag on the next edge. If an edge is detected in the same cycle as the clear, the flag ends set.
- R7: In a level mode, a clear pulse taken while the level is still active drives the flag to 0 for one cycle, and the flag is set again on the following edge.
- R8: With destination bit 0, a set flag of an enabled channel appears on that channel's interrupt request and its transfer request stays 0. With destination bit 1, the flag appears on the transfer request and the interrupt request stays 0.
- R9: A one-cycle transfer acknowledge clears the flag of a channel whose destination bit is 1. It has no effect on a channel whose destination bit is 0.
- R10: Any change of a channel's 2-bit mode field clears that channel's flag on the next edge.
- R11: A channel with enable 0 has its flag cleared on the next edge and never sets it. Both of its request outputs stay 0.
- R12: The wake-up output is 1 while any input whose wake-up enable bit is 1 is low after synchronization, two edges after the input changes. It is 0 when no such input is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NCH | Asynchronous external request lines |
| en_i | input | NCH | Per-channel detection enable |
| mode_i | input | 2*NCH | Per-channel mode field, channel i at bits 2i+1:2i |
| dst_i | input | NCH | Per-channel destination: 0 interrupt, 1 data transfer |
| clr_i | input | NCH | Write-one flag clear pulses |
| ack_i | input | NCH | Transfer-engine acknowledge pulses |
| wake_en_i | input | NCH | Per-input wake-up enable |
| flag_o | output | NCH | Flag register contents |
| irq_o | output | NCH | Per-channel CPU interrupt requests |
| dtr_o | output | NCH | Per-channel data-transfer start requests |
| wake_o | output | 1 | Wake-up request |

## Verification
The hardest case to reach from the ports is an edge event and a software clear landing in the same cycle. That cycle exists only inside the synchronizer pipeline, never at the pins. The stimulus drives the pin, waits exactly two clock edges for the new value to reach the last synchronizer stage, and then pulses the clear for one cycle. The bench then expects the flag to survive. A similar timed clear during an active level checks the one-cycle dip and the re-set that follows. A mode write on a channel whose input is already high confirms that switching to falling-edge mode neither keeps the old flag nor invents an edge.

// File: rtl/xreq_pkg.sv
`timescale 1ns/1ps
package xreq_pkg;

   // Detection condition per channel; bit 1 set means a level condition.
   typedef enum logic [1:0] {
      DET_RISE = 2'b00,
      DET_FALL = 2'b01,
      DET_HIGH = 2'b10,
      DET_LOW  = 2'b11
   } det_mode_e;

   function automatic logic det_is_level(input det_mode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/xreq_sync.sv
`timescale 1ns/1ps
module xreq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[k] <= 1'b0;
            else        chain[k] <= chain[k-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/xreq_chan.sv
`timescale 1ns/1ps
module xreq_chan
   import xreq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin_i,
   input  logic      en_i,
   input  det_mode_e mode_i,
   input  logic      dst_i,
   input  logic      clr_i,
   input  logic      ack_i,
   output logic      lvl_o,
   output logic      flag_o
);
   logic      lvl_q;
   logic      prev_q;
   logic      hit;
   logic      wipe;
   logic      mode_moved;
   det_mode_e mode_q;

   xreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (lvl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_q;
   end

   // Plain register: tracks the mode field so a rewrite can be seen.
   always_ff @(posedge clk) mode_q <= mode_i;

   assign mode_moved = (mode_q != mode_i);

   always_comb begin
      unique case (mode_i)
         DET_RISE: hit = lvl_q & ~prev_q;
         DET_FALL: hit = ~lvl_q & prev_q;
         DET_HIGH: hit = lvl_q;
         DET_LOW:  hit = ~lvl_q;
      endcase
   end

   assign wipe = clr_i | (ack_i & dst_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
      end else if (!en_i || mode_moved) begin
         flag_o <= 1'b0;
      end else if (det_is_level(mode_i)) begin
         flag_o <= hit & ~wipe;
      end else if (hit) begin
         flag_o <= 1'b1;
      end else if (wipe) begin
         flag_o <= 1'b0;
      end
   end

   assign lvl_o = lvl_q;
endmodule

// File: rtl/xreq_detect.sv
`timescale 1ns/1ps
module xreq_detect
   import xreq_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   pin_i,
   input  logic [NCH-1:0]   en_i,
   input  logic [2*NCH-1:0] mode_i,
   input  logic [NCH-1:0]   dst_i,
   input  logic [NCH-1:0]   clr_i,
   input  logic [NCH-1:0]   ack_i,
   input  logic [NCH-1:0]   wake_en_i,
   output logic [NCH-1:0]   flag_o,
   output logic [NCH-1:0]   irq_o,
   output logic [NCH-1:0]   dtr_o,
   output logic             wake_o
);
   localparam int MODE_W = 2;

   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("xreq_detect: NCH must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xreq_detect: SYNC_STAGES must be at least 2");
   end

   logic [NCH-1:0] lvl;
   logic [NCH-1:0] flag;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      xreq_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (pin_i[i]),
         .en_i   (en_i[i]),
         .mode_i (det_mode_e'(mode_i[MODE_W*i +: MODE_W])),
         .dst_i  (dst_i[i]),
         .clr_i  (clr_i[i]),
         .ack_i  (ack_i[i]),
         .lvl_o  (lvl[i]),
         .flag_o (flag[i])
      );
   end

   assign flag_o = flag;
   assign irq_o  = flag & en_i & ~dst_i;
   assign dtr_o  = flag & en_i & dst_i;
   assign wake_o = |(wake_en_i & ~lvl);
endmodule

// File: rtl/xreq_detect_chk.sv
`timescale 1ns/1ps
module xreq_detect_chk #(
   parameter int NCH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NCH-1:0]   en_i,
   input logic [2*NCH-1:0] mode_i,
   input logic [NCH-1:0]   dst_i,
   input logic [NCH-1:0]   clr_i,
   input logic [NCH-1:0]   ack_i,
   input logic [NCH-1:0]   wake_en_i,
   input logic [NCH-1:0]   flag_o,
   input logic [NCH-1:0]   irq_o,
   input logic [NCH-1:0]   dtr_o,
   input logic             wake_o
);
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      // R2: an edge-mode flag holds while nothing clears it
      a_r2_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_o[i] && en_i[i] && !mode_i[2*i+1] && $stable(mode_i[2*i +: 2])
          && !clr_i[i] && !(ack_i[i] && dst_i[i])) |=> flag_o[i]);

      // R8: a request only appears for a set flag, never on both outputs
      a_r8_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_o[i] || dtr_o[i]) |-> (flag_o[i] && !(irq_o[i] && dtr_o[i])));

      // R10: rewriting the mode field empties the flag
      a_r10_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i[2*i +: 2] != $past(mode_i[2*i +: 2])) |=> !flag_o[i]);

      // R11: a disabled channel holds no flag on the next edge
      a_r11_disabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
         !en_i[i] |=> !flag_o[i]);

      // R11: a disabled channel drives no request
      a_r11_disabled_req: assert property (@(posedge clk) disable iff (!rst_n)
         !en_i[i] |-> (!irq_o[i] && !dtr_o[i]));
   end

   // R12: no wake-up without any wake-up enable
   a_r12_wake_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_en_i == '0) |-> !wake_o);
endmodule

bind xreq_detect xreq_detect_chk #(.NCH(NCH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en_i      (en_i),
   .mode_i    (mode_i),
   .dst_i     (dst_i),
   .clr_i     (clr_i),
   .ack_i     (ack_i),
   .wake_en_i (wake_en_i),
   .flag_o    (flag_o),
   .irq_o     (irq_o),
   .dtr_o     (dtr_o),
   .wake_o    (wake_o)
);

// File: tb/xreq_detect_test.sv
`timescale 1ns/1ps
module xreq_detect_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pin = '0;
   logic [7:0]  en = '0;
   logic [15:0] mode = '0;
   logic [7:0]  dst = '0;
   logic [7:0]  clr = '0;
   logic [7:0]  ack = '0;
   logic [7:0]  wen = '0;
   logic [7:0]  flag, irq, dtr;
   logic        wake;

   typedef struct {
      int unsigned due;
      logic [7:0]  f;
      logic [7:0]  irq;
      logic [7:0]  dtr;
      logic        w;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   int unsigned cyc = 0;
   int          nvec = 0;
   int          nbad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   xreq_detect uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin),
      .en_i      (en),
      .mode_i    (mode),
      .dst_i     (dst),
      .clr_i     (clr),
      .ack_i     (ack),
      .wake_en_i (wen),
      .flag_o    (flag),
      .irq_o     (irq),
      .dtr_o     (dtr),
      .wake_o    (wake)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compare each expected item at the negedge of its cycle.
   always @(negedge clk) begin
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
         exp_t it;
         it = exp_q.pop_front();
         nvec++;
         if (it.due != cyc || flag !== it.f || irq !== it.irq ||
             dtr !== it.dtr || wake !== it.w) begin
            nbad++;
            $display("FAIL %s @%0d: got flag=%h irq=%h dtr=%h wake=%b, want flag=%h irq=%h dtr=%h wake=%b",
                     it.tag, cyc, flag, irq, dtr, wake, it.f, it.irq, it.dtr, it.w);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // Driver side: queue what the outputs must be d edges from now.
   task automatic chk(input int d, input logic [7:0] f, input logic w, input string tag);
      exp_t it;
      it.due = cyc + d;
      it.f   = f;
      it.irq = f & ~dst;
      it.dtr = f & dst;
      it.w   = w;
      it.tag = tag;
      exp_q.push_back(it);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      chk(1, 8'h00, 1'b0, "R1 reset state");
      chk(2, 8'h00, 1'b0, "R1 reset state held");
      idle(3);

      // Channel 0 rising edge, interrupt destination
      en = 8'h01;
      idle(2);
      pin[0] = 1'b1;
      chk(2, 8'h00, 1'b0, "R2 no flag before third edge");
      chk(3, 8'h01, 1'b0, "R2 rising edge sets flag");
      idle(5);
      pin[0] = 1'b0;
      chk(3, 8'h01, 1'b0, "R2 sticky after release, R8 irq route");
      idle(5);
      clr = 8'h01;
      chk(1, 8'h00, 1'b0, "R6 clear pulse");
      idle(1);
      clr = 8'h00;
      idle(3);
      pin[0] = 1'b1;
      idle(2);
      clr = 8'h01;
      chk(1, 8'h01, 1'b0, "R6 edge beats simultaneous clear");
      idle(1);
      clr = 8'h00;
      idle(2);
      ack = 8'h01;
      chk(1, 8'h01, 1'b0, "R9 ack ignored on irq channel");
      idle(1);
      ack = 8'h00;
      idle(2);

      // Mode rewrite while input high, then falling edge
      mode[1:0] = 2'b01;
      chk(1, 8'h00, 1'b0, "R10 mode change clears flag");
      chk(3, 8'h00, 1'b0, "R10 no false edge after switch");
      idle(4);
      pin[0] = 1'b0;
      chk(3, 8'h01, 1'b0, "R3 falling edge sets flag");
      idle(4);

      // Channel 1 rising edge, transfer destination
      en  = 8'h03;
      dst = 8'h02;
      idle(2);
      pin[1] = 1'b1;
      chk(3, 8'h03, 1'b0, "R8 transfer route");
      idle(4);
      ack = 8'h02;
      chk(1, 8'h01, 1'b0, "R9 ack clears transfer channel");
      idle(1);
      ack = 8'h00;
      idle(2);

      // Channel 2 high level
      en = 8'h07;
      mode[5:4] = 2'b10;
      idle(3);
      pin[2] = 1'b1;
      chk(2, 8'h01, 1'b0, "R4 level latency");
      chk(3, 8'h05, 1'b0, "R4 high level sets flag");
      idle(4);
      clr = 8'h04;
      chk(1, 8'h01, 1'b0, "R7 clear dips level flag");
      idle(1);
      clr = 8'h00;
      chk(1, 8'h05, 1'b0, "R7 level flag sets again");
      idle(3);
      pin[2] = 1'b0;
      chk(2, 8'h05, 1'b0, "R4 flag still up two edges after drop");
      chk(3, 8'h01, 1'b0, "R4 flag follows level down");
      idle(4);

      // Channel 3 low level
      pin[3] = 1'b1;
      idle(3);
      en = 8'h0F;
      mode[7:6] = 2'b11;
      idle(3);
      pin[3] = 1'b0;
      chk(3, 8'h09, 1'b0, "R5 low level sets flag");
      idle(4);
      pin[3] = 1'b1;
      chk(3, 8'h01, 1'b0, "R5 flag drops when high");
      idle(4);

      // Disable channel 0
      en = 8'h0E;
      chk(1, 8'h00, 1'b0, "R11 disable clears flag and request");
      idle(2);
      pin[0] = 1'b1;
      idle(4);
      pin[0] = 1'b0;
      chk(3, 8'h00, 1'b0, "R11 disabled channel ignores edge");
      chk(5, 8'h00, 1'b0, "R11 disabled channel stays idle");
      idle(6);

      // Wake-up on input 4
      wen = 8'h10;
      chk(1, 8'h00, 1'b1, "R12 wake on enabled low input");
      idle(2);
      pin[4] = 1'b1;
      chk(1, 8'h00, 1'b1, "R12 wake held during sync");
      chk(2, 8'h00, 1'b0, "R12 wake released");
      idle(4);

      idle(2);
      while (exp_q.size() > 0) begin
         exp_t it;
         it = exp_q.pop_front();
         nvec++;
         nbad++;
         $display("FAIL %s: never compared, want flag=%h", it.tag, it.f);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: run hung, got done=%b, want done=1", done);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule